// File: doc/BRIEF.md
# Hardware Monitor Limit Checker with Interrupt Output

This block walks round a fixed set of monitored channels (supply voltages, fan tachometer period counts and one temperature) and, on each step, compares the channel's present reading against a programmable upper and lower bound. A reading outside its bounds sets a sticky status bit for that channel. The status bits drive an interrupt pin and an active-low SMI-style pin. A configuration byte selects whether the interrupt pin is a level or a fixed-width pulse, sets its polarity, and gates each output. The same byte also holds a run bit, a self-clearing reinitialise bit, a watchdog-enable bit and a hold bit. The hold bit masks both outputs and parks the scan.

Readings are plain level inputs that the block samples when the scan reaches them, so they carry no handshake and nothing pushes back on them. Software reaches the configuration, status and limit bytes through a simple one-cycle read/write port. Read data appears on the cycle after the read strobe. The analog front end, the serial bus and the watchdog counter are outside this block.

Register addresses: 0 is the configuration byte, 1 is the status byte (read-only, bit n belongs to channel n), and 2+2n / 3+2n are the upper / lower limits of channel n. Channels 0..NUM_VOLT-1 are voltages, the next NUM_FAN are fans and the last channel is the temperature. Configuration bits: 0 run, 1 SMI enable, 2 IRQ enable, 3 hold, 4 watchdog enable, 5 polarity (1 = active low), 6 pulse mode, 7 reinitialise.

Top module: `mon_limit_irq`

## Requirements
- R1: After reset the configuration byte reads 0x01. The status is zero. Every voltage and fan upper limit reads 0xFF, the temperature upper limit reads 0x7F and every lower limit reads 0x00. irq_pin is low and smi_n is high.
- R2: While run (bit 0) is 1, the scan compares exactly one channel per clock in ascending order, wrapping from the last channel to channel 0. While run is 0, no channel is compared and no status bit is set.
- R3: A voltage channel sets its status bit when its unsigned reading is above its upper limit or below its lower limit. An upper limit of 0xFF never produces an upper violation.
- R4: A fan reading is a period count, so a count above the upper limit means the fan is too slow and sets the bit. A count below the lower limit also sets it. An upper limit of 0xFF never trips.
- R5: The temperature reading and its limits are two's complement. A temperature above the upper limit or below the lower limit sets the bit, and an upper limit of 0x7F never trips.
- R6: Status bits are sticky and are cleared by a read of address 1. A violation found in the same cycle as that read is kept.
- R7: Writes to address 1 change no status bit and do not release the interrupt or SMI outputs.
- R8: In level mode (bit 6 = 0), the interrupt is active while IRQ enable is 1 and any status bit is set. irq_pin equals the active state XOR bit 5.
- R9: In pulse mode, a status bit going from 0 to 1 while IRQ enable is 1 starts an active pulse of exactly PULSE_CYCLES clocks. A further event during a pulse neither extends nor restarts it.
- R10: smi_n is low while SMI enable is 1 and any status bit is set, and high otherwise.
- R11: While hold (bit 3) is 1, irq_pin sits at its inactive level and smi_n is high, and the status bits are kept. The scan stops once it has compared the last channel and resumes at channel 0 after hold returns to 0.
- R12: Writing the configuration byte with bit 7 set restores every register to its R1 value. Bit 7 always reads back as 0.
- R13: wdog_en follows configuration bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reading_i | input | NCH*DW | Latest reading of each channel, channel n in bits n*DW +: DW |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid the cycle after reg_rd |
| irq_pin | output | 1 | Interrupt pin, level or pulse, selectable polarity |
| smi_n | output | 1 | SMI-style alert, active low |
| status_o | output | NCH | Sticky violation bits |
| wdog_en | output | 1 | Watchdog enable from the configuration byte |

## Verification
The assertions assume that reg_wr and reg_rd are never high in the same cycle, and that the reinitialise write is never combined with a read. They also assume reset is held for at least one clock before the block runs. The stimulus keeps to these rules: every register access goes through one write task and one read task, and each task raises a single strobe for one cycle. Readings change only between clock edges. Each reading is held for at least one full scan pass before the status is checked, so every channel has been compared at least once.

// File: rtl/mon_pkg.sv
package mon_pkg;
  localparam int BIT_RUN    = 0;
  localparam int BIT_SMI_EN = 1;
  localparam int BIT_IRQ_EN = 2;
  localparam int BIT_HOLD   = 3;
  localparam int BIT_WDOG   = 4;
  localparam int BIT_POL    = 5;
  localparam int BIT_PULSE  = 6;
  localparam int BIT_INIT   = 7;

  localparam int ADDR_CFG      = 0;
  localparam int ADDR_STAT     = 1;
  localparam int ADDR_LIM_BASE = 2;

  typedef enum logic [1:0] {CH_VOLT, CH_FAN, CH_TEMP} ch_kind_e;

  function automatic ch_kind_e kind_of(int c, int nv, int nf);
    if (c < nv)      return CH_VOLT;
    if (c < nv + nf) return CH_FAN;
    return CH_TEMP;
  endfunction
endpackage

// File: rtl/mon_regs.sv
module mon_regs #(
  parameter int NCH = 7,
  parameter int DW  = 8,
  parameter int AW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic              init_req,
  output logic [DW-1:0]     cfg,
  output logic [NCH*DW-1:0] hi_flat,
  output logic [NCH*DW-1:0] lo_flat
);
  import mon_pkg::*;
  localparam logic [DW-1:0] CFG_DEF    = DW'(1);
  localparam logic [DW-1:0] HI_DEF     = '1;
  localparam logic [DW-1:0] TEMP_NEVER = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] cfg_q;
  logic [DW-1:0] hi_q [NCH];
  logic [DW-1:0] lo_q [NCH];

  assign init_req = wr && (addr == AW'(ADDR_CFG)) && wdata[BIT_INIT];
  assign cfg      = cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n || init_req) begin
      cfg_q <= CFG_DEF;
      for (int c = 0; c < NCH; c++) begin
        hi_q[c] <= (c == NCH - 1) ? TEMP_NEVER : HI_DEF;
        lo_q[c] <= '0;
      end
    end else if (wr) begin
      if (addr == AW'(ADDR_CFG)) cfg_q <= wdata;
      for (int c = 0; c < NCH; c++) begin
        if (addr == AW'(ADDR_LIM_BASE + 2 * c))     hi_q[c] <= wdata;
        if (addr == AW'(ADDR_LIM_BASE + 2 * c + 1)) lo_q[c] <= wdata;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign hi_flat[c*DW +: DW] = hi_q[c];
    assign lo_flat[c*DW +: DW] = lo_q[c];
  end
endmodule

// File: rtl/mon_scan.sv
module mon_scan #(
  parameter int NCH = 7,
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_req,
  input  logic          run_en,
  input  logic          hold,
  output logic          run,
  output logic          halted,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NCH - 1);

  logic [PW-1:0] ptr_q;
  logic          halt_q;

  assign run    = run_en && !halt_q;
  assign halted = halt_q;
  assign ptr    = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || init_req) begin
      ptr_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      if (run) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
      if (!hold)                      halt_q <= 1'b0;
      else if (run && ptr_q == LAST)  halt_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mon_cmp.sv
module mon_cmp #(
  parameter int NCH      = 7,
  parameter int DW       = 8,
  parameter int NUM_VOLT = 4,
  parameter int NUM_FAN  = 2,
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH*DW-1:0] reading,
  input  logic [NCH*DW-1:0] hi_flat,
  input  logic [NCH*DW-1:0] lo_flat,
  input  logic              run,
  input  logic [PW-1:0]     ptr,
  output logic [NCH-1:0]    hit
);
  import mon_pkg::*;
  logic [NCH-1:0] viol;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam ch_kind_e KIND = kind_of(c, NUM_VOLT, NUM_FAN);
    logic [DW-1:0] r, h, l;
    assign r = reading[c*DW +: DW];
    assign h = hi_flat[c*DW +: DW];
    assign l = lo_flat[c*DW +: DW];
    if (KIND == CH_TEMP) begin : g_signed
      assign viol[c] = ($signed(r) > $signed(h)) || ($signed(r) < $signed(l));
    end else begin : g_unsigned
      // fan: a larger period count is a slower fan
      assign viol[c] = (r > h) || (r < l);
    end
  end

  assign hit = run ? (viol & (NCH'(1) << ptr)) : '0;
endmodule

// File: rtl/mon_alert.sv
module mon_alert #(
  parameter int NCH          = 7,
  parameter int PULSE_CYCLES = 10000,
  localparam int CW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_req,
  input  logic [NCH-1:0] hit,
  input  logic           stat_rd,
  input  logic           irq_en,
  input  logic           smi_en,
  input  logic           hold,
  input  logic           pol_low,
  input  logic           pulse_mode,
  output logic [NCH-1:0] status,
  output logic           irq_pin,
  output logic           smi_n
);
  logic [NCH-1:0] stat_q;
  logic [CW-1:0]  pcnt_q;
  logic           fresh, irq_act;

  assign fresh = |(hit & ~stat_q);

  always_ff @(posedge clk) begin
    if (!rst_n || init_req) begin
      stat_q <= '0;
      pcnt_q <= '0;
    end else begin
      stat_q <= (stat_rd ? '0 : stat_q) | hit;
      if (pcnt_q != '0)
        pcnt_q <= pcnt_q - CW'(1);
      else if (pulse_mode && irq_en && !hold && fresh)
        pcnt_q <= CW'(PULSE_CYCLES);
    end
  end

  assign irq_act = irq_en && !hold && (pulse_mode ? (pcnt_q != '0) : (|stat_q));
  assign irq_pin = irq_act ^ pol_low;
  assign smi_n   = !(smi_en && !hold && (|stat_q));
  assign status  = stat_q;
endmodule

// File: rtl/mon_limit_irq.sv
module mon_limit_irq #(
  parameter int NUM_VOLT     = 4,
  parameter int NUM_FAN      = 2,
  parameter int DW           = 8,
  parameter int AW           = 6,
  parameter int PULSE_CYCLES = 10000,
  localparam int NCH = NUM_VOLT + NUM_FAN + 1,
  localparam int PW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*DW-1:0] reading_i,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_pin,
  output logic              smi_n,
  output logic [NCH-1:0]    status_o,
  output logic              wdog_en
);
  import mon_pkg::*;

  logic              init_req, scan_run, scan_halt, stat_rd;
  logic [DW-1:0]     cfg_q, rdata_q;
  logic [NCH*DW-1:0] hi_flat, lo_flat;
  logic [PW-1:0]     scan_ptr;
  logic [NCH-1:0]    hit;

  mon_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .init_req, .cfg(cfg_q), .hi_flat, .lo_flat
  );

  mon_scan #(.NCH(NCH)) u_scan (
    .clk, .rst_n, .init_req, .run_en(cfg_q[BIT_RUN]), .hold(cfg_q[BIT_HOLD]),
    .run(scan_run), .halted(scan_halt), .ptr(scan_ptr)
  );

  mon_cmp #(.NCH(NCH), .DW(DW), .NUM_VOLT(NUM_VOLT), .NUM_FAN(NUM_FAN)) u_cmp (
    .reading(reading_i), .hi_flat, .lo_flat, .run(scan_run), .ptr(scan_ptr), .hit
  );

  assign stat_rd = reg_rd && (reg_addr == AW'(ADDR_STAT));

  mon_alert #(.NCH(NCH), .PULSE_CYCLES(PULSE_CYCLES)) u_alert (
    .clk, .rst_n, .init_req, .hit, .stat_rd,
    .irq_en(cfg_q[BIT_IRQ_EN]), .smi_en(cfg_q[BIT_SMI_EN]), .hold(cfg_q[BIT_HOLD]),
    .pol_low(cfg_q[BIT_POL]), .pulse_mode(cfg_q[BIT_PULSE]),
    .status(status_o), .irq_pin, .smi_n
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      if (reg_addr == AW'(ADDR_CFG))  rdata_q <= cfg_q;
      if (reg_addr == AW'(ADDR_STAT)) rdata_q <= DW'(status_o);
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == AW'(ADDR_LIM_BASE + 2 * c))     rdata_q <= hi_flat[c*DW +: DW];
        if (reg_addr == AW'(ADDR_LIM_BASE + 2 * c + 1)) rdata_q <= lo_flat[c*DW +: DW];
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign wdog_en   = cfg_q[BIT_WDOG];
endmodule

// File: rtl/mon_limit_irq_chk.sv
module mon_limit_irq_chk #(
  parameter int NCH = 7,
  parameter int DW  = 8,
  parameter int PW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [DW-1:0]  cfg,
  input logic [NCH-1:0] stat,
  input logic           irq_pin,
  input logic           smi_n,
  input logic [PW-1:0]  ptr,
  input logic           halted,
  input logic           stat_rd,
  input logic           init_req
);
  // R11
  hold_masks_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[3] |-> (irq_pin == cfg[5]) && smi_n);

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !init_req) |=> ((stat & $past(stat)) == $past(stat)));

  // R2
  one_channel_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(stat & ~$past(stat)) <= 1));

  // R2
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NCH - 1));

  // R11
  park_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (ptr == '0));

  // R12
  init_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (cfg == DW'(1)) && (stat == '0));

  // R10
  smi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> smi_n);
endmodule

bind mon_limit_irq mon_limit_irq_chk #(.NCH(NCH), .DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .stat(status_o), .irq_pin(irq_pin),
  .smi_n(smi_n), .ptr(scan_ptr), .halted(scan_halt), .stat_rd(stat_rd),
  .init_req(init_req)
);

// File: tb/test_mon_limit_irq.sv
module test_mon_limit_irq;
  localparam int NV = 4, NF = 2, NCH = 7, DW = 8, AW = 6, P = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_pin, smi_n, wdog_en;
  logic [NCH-1:0] status_o;
  logic [7:0] rv [NCH];
  logic [NCH*DW-1:0] reading;

  always #10 clk = ~clk;

  always_comb for (int c = 0; c < NCH; c++) reading[c*DW +: DW] = rv[c];

  mon_limit_irq #(.NUM_VOLT(NV), .NUM_FAN(NF), .DW(DW), .AW(AW), .PULSE_CYCLES(P)) i_mon_limit_irq (
    .clk, .rst_n, .reading_i(reading), .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .irq_pin, .smi_n, .status_o, .wdog_en
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_cfg, m_rdata;
  logic [7:0] m_hi [NCH];
  logic [7:0] m_lo [NCH];
  int m_stat, m_ptr, m_pcnt;
  bit m_halt;

  task automatic m_defaults();
    m_cfg = 8'h01; m_stat = 0; m_ptr = 0; m_pcnt = 0; m_halt = 0;
    for (int c = 0; c < NCH; c++) begin
      m_hi[c] = (c == NCH - 1) ? 8'h7F : 8'hFF;
      m_lo[c] = 8'h00;
    end
  endtask

  function automatic logic [7:0] m_read(input int a);
    if (a == 0) return m_cfg;
    if (a == 1) return 8'(m_stat);
    for (int c = 0; c < NCH; c++) begin
      if (a == 2 + 2 * c) return m_hi[c];
      if (a == 3 + 2 * c) return m_lo[c];
    end
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    int hitv, newb;
    bit run, v;
    if (reg_rd) m_rdata = m_read(int'(reg_addr));
    if (!rst_n) begin
      m_defaults();
      m_rdata = 8'h00;
    end else if (reg_wr && reg_addr == 0 && reg_wdata[7]) begin
      m_defaults();
    end else begin
      hitv = 0;
      run = m_cfg[0] && !m_halt;
      if (run) begin
        if (m_ptr == NCH - 1)
          v = ($signed(rv[m_ptr]) > $signed(m_hi[m_ptr])) || ($signed(rv[m_ptr]) < $signed(m_lo[m_ptr]));
        else
          v = (rv[m_ptr] > m_hi[m_ptr]) || (rv[m_ptr] < m_lo[m_ptr]);
        if (v) hitv = 1 << m_ptr;
      end
      newb = hitv & ~m_stat;
      if (m_pcnt > 0) m_pcnt--;
      else if (m_cfg[6] && m_cfg[2] && !m_cfg[3] && newb != 0) m_pcnt = P;
      if (reg_rd && reg_addr == 1) m_stat = 0;
      m_stat |= hitv;
      if (!m_cfg[3]) m_halt = 0;
      else if (run && m_ptr == NCH - 1) m_halt = 1;
      if (run) m_ptr = (m_ptr == NCH - 1) ? 0 : m_ptr + 1;
      if (reg_wr) begin
        if (reg_addr == 0) m_cfg = reg_wdata;
        for (int c = 0; c < NCH; c++) begin
          if (reg_addr == AW'(2 + 2 * c)) m_hi[c] = reg_wdata;
          if (reg_addr == AW'(3 + 2 * c)) m_lo[c] = reg_wdata;
        end
      end
    end
  end

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    bit act;
    if (rst_n && !done) begin
      act = m_cfg[2] && !m_cfg[3] && (m_cfg[6] ? (m_pcnt != 0) : (m_stat != 0));
      chk("R8 irq_pin vs model", irq_pin, act ^ m_cfg[5]);
      chk("R10 smi_n vs model", smi_n, !(m_cfg[1] && !m_cfg[3] && m_stat != 0));
      chk("R6 status vs model", status_o, m_stat);
      chk("R12 rdata vs model", reg_rdata, m_rdata);
      chk("R13 wdog_en vs model", wdog_en, m_cfg[4]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired act=%0d exp=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1; reg_addr = AW'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_rd = 1; reg_addr = AW'(a);
    @(negedge clk); v = int'(reg_rdata); reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v, hi_cnt;
    for (int c = 0; c < NCH; c++) rv[c] = 8'h80;
    rv[NCH-1] = 8'h20;
    rv[5] = 8'hFF;
    rv[1] = 8'hFF;
    idle(4);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 irq_pin", irq_pin, 0);
    chk("R1 smi_n", smi_n, 1);
    chk("R1 status", status_o, 0);
    rd(0, v);  chk("R1 cfg", v, 8'h01);
    rd(2, v);  chk("R1 volt hi", v, 8'hFF);
    rd(14, v); chk("R1 temp hi", v, 8'h7F);
    rd(15, v); chk("R1 temp lo", v, 8'h00);
    // R3 voltage below low; 0xFF hi never trips (rv1 = 0xFF)
    wr(2, 8'hA0); wr(3, 8'h40); wr(0, 8'h07);
    rv[0] = 8'h30; idle(10);
    chk("R3 volt status", status_o, 7'h01);
    chk("R8 level irq", irq_pin, 1);
    chk("R10 smi active", smi_n, 0);
    // R7 write to status ignored
    wr(1, 8'h00); idle(2);
    chk("R7 status kept", status_o, 7'h01);
    chk("R7 irq kept", irq_pin, 1);
    // R6 read clears
    rv[0] = 8'h80; idle(10);
    rd(1, v); chk("R6 read value", v, 8'h01);
    idle(2);
    chk("R6 cleared", status_o, 0);
    chk("R8 irq released", irq_pin, 0);
    // R4 fan too slow and too fast; fan hi 0xFF never trips (rv5)
    wr(10, 8'h90); rv[4] = 8'hA0; idle(10);
    chk("R4 fan slow", status_o, 7'h10);
    rv[4] = 8'h80; rd(1, v); idle(10);
    chk("R4 fan clear", status_o, 0);
    wr(11, 8'h20); rv[4] = 8'h10; idle(10);
    chk("R4 fan fast", status_o, 7'h10);
    rv[4] = 8'h80; idle(2); rd(1, v); idle(10);
    // R5 signed temperature
    wr(15, 8'hE0); rv[6] = 8'hF0; idle(10);
    chk("R5 -16 within", status_o, 0);
    rv[6] = 8'h7F; idle(10);
    chk("R5 0x7F never", status_o, 0);
    rv[6] = 8'hD0; idle(10);
    chk("R5 -48 below", status_o, 7'h40);
    rv[6] = 8'h20; idle(2); rd(1, v); idle(10);
    // R8 polarity
    wr(0, 8'h27); idle(2);
    chk("R8 inactive high", irq_pin, 1);
    rv[0] = 8'h30; idle(10);
    chk("R8 active low", irq_pin, 0);
    rv[0] = 8'h80; idle(2); rd(1, v); idle(10);
    // R9 pulse, second event does not extend
    wr(5, 8'h40); wr(0, 8'h45);
    rv[0] = 8'h30; rv[1] = 8'h10;
    hi_cnt = 0;
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk);
      if (irq_pin) hi_cnt++;
    end
    chk("R9 pulse width", hi_cnt, P);
    chk("R9 both bits", status_o, 7'h03);
    rv[0] = 8'h80; rv[1] = 8'h80; idle(2); rd(1, v); idle(P + 10);
    // R11 hold
    wr(0, 8'h07); rv[0] = 8'h30; idle(10);
    wr(0, 8'h0F); idle(10);
    chk("R11 irq masked", irq_pin, 0);
    chk("R11 smi masked", smi_n, 1);
    chk("R11 status kept", status_o, 7'h01);
    rd(1, v); idle(20);
    chk("R11 scan parked", status_o, 0);
    wr(0, 8'h07); idle(10);
    chk("R11 scan resumed", status_o, 7'h01);
    rv[0] = 8'h80; idle(2); rd(1, v); idle(10);
    // R2 run bit
    wr(0, 8'h06); rv[0] = 8'h30; idle(20);
    chk("R2 no scan when stopped", status_o, 0);
    wr(0, 8'h07); idle(10);
    chk("R2 scan when running", status_o, 7'h01);
    rv[0] = 8'h80; idle(2); rd(1, v); idle(10);
    // R12 reinitialise
    wr(2, 8'h55); wr(0, 8'h80);
    rd(0, v); chk("R12 cfg default", v, 8'h01);
    rd(2, v); chk("R12 hi default", v, 8'hFF);
    rd(3, v); chk("R12 lo default", v, 8'h00);
    chk("R12 status", status_o, 0);
    // R13 watchdog enable
    wr(0, 8'h11); idle(1);
    chk("R13 wdog on", wdog_en, 1);
    wr(0, 8'h01); idle(1);
    chk("R13 wdog off", wdog_en, 0);
    idle(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule